// File: doc/BRIEF.md
# Dual-Slot Accumulator Fetch/Execute Sequencer

This block is the sequencer and datapath of a small accumulator machine. Each memory word is 40 bits wide and packs two 20-bit instructions. The block fetches one word, keeps the second instruction in a buffer register and runs both halves before it fetches again. A jump discards the buffered half. It holds a program counter, a memory address register, a memory buffer register, an instruction register, an instruction buffer register and an accumulator.

All memory traffic goes through one word-addressed port. The block raises a request with an address, a write enable and write data, and holds them until the memory answers with ready. Read data is taken in the cycle ready is high. The supported operations are load, store, add, subtract, unconditional jump and halt. Every other opcode is skipped as a no-op. After a halt the sequencer freezes and reports it on a status output.

Top module: `dual_slot_acc_seq`

## Requirements
- R1: While reset is active and right after it is released, `halted` is 0 and `acc` is 0. The first memory access after reset is a read of word 0.
- R2: Within a word, the left instruction is bits [19:0] (opcode [7:0], address [19:8]) and the right instruction is bits [39:20] (opcode [27:20], address [39:28]). The left instruction runs first. The right one then runs from the buffer, without another read of that word.
- R3: Load (opcode 8'h01) puts the 40-bit word at the operand address into the accumulator.
- R4: Add (opcode 8'h03) sets the accumulator to accumulator plus operand, modulo 2^40.
- R5: Subtract (opcode 8'h04) sets the accumulator to accumulator minus operand, modulo 2^40.
- R6: Store (opcode 8'h02) writes the accumulator to the operand address and leaves the accumulator unchanged.
- R7: Jump (opcode 8'h05) in either half makes the next memory access a read of the target word. A pending right instruction is discarded and never runs.
- R8: Halt (opcode 8'hFF) sets `halted` to 1 for good. No further memory request is made, and the accumulator no longer changes.
- R9: Any other opcode, including 8'h00, has no effect: no memory access and no accumulator change. The sequencer moves on to the next instruction.
- R10: A request holds its address, write enable and data until `mem_ready`. Any number of wait cycles gives the same results.
- R11: After both halves of a word have run without a jump, the program counter advances by one, so the next instruction read is the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read (valid with mem_req) |
| mem_addr | output | 12 | Word address |
| mem_wdata | output | 40 | Write data (accumulator) |
| mem_rdata | input | 40 | Read data, valid when mem_ready is 1 |
| mem_ready | input | 1 | Completes the pending access this cycle |
| halted | output | 1 | Sequencer is stopped by a halt |
| acc | output | 40 | Accumulator value |

## Verification
Two events can coincide when a jump sits in the right half: the end of the word, which normally advances the program counter, and the jump, which loads the target. A program with a load on the left and a jump on the right provokes this. The check is that word 1 is never read and the target word is. A second coincidence is a request answered in its first cycle against one that must wait. The same programs run with zero and with three wait states and must give equal results, while the memory model counts any change of the request during a wait.

// File: rtl/dual_slot_acc_seq.sv
module dual_slot_acc_seq #(
  parameter int WORD_W = 40,
  parameter int OP_W = 8,
  parameter logic [7:0] OP_LOAD = 8'h01,
  parameter logic [7:0] OP_STORE = 8'h02,
  parameter logic [7:0] OP_ADD = 8'h03,
  parameter logic [7:0] OP_SUB = 8'h04,
  parameter logic [7:0] OP_JUMP = 8'h05,
  parameter logic [7:0] OP_HALT = 8'hFF,
  localparam int HALF_W = WORD_W / 2,
  localparam int ADDR_W = HALF_W - OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              halted,
  output logic [WORD_W-1:0] acc
);

  typedef enum logic [2:0] {
    S_FADR, S_FMEM, S_SPLIT, S_DEC, S_OMEM, S_EXEC, S_NEXT, S_HALT
  } st_t;

  st_t st;
  logic [ADDR_W-1:0] pc, mar;
  logic [WORD_W-1:0] mbr, ac;
  logic [HALF_W-1:0] ir, ibr;
  logic ibr_full;

  wire [OP_W-1:0]   ir_op  = ir[OP_W-1:0];
  wire [ADDR_W-1:0] ir_adr = ir[HALF_W-1:OP_W];
  wire is_mem_op = (ir_op == OP_LOAD) || (ir_op == OP_STORE) ||
                   (ir_op == OP_ADD) || (ir_op == OP_SUB);

  assign mem_req   = (st == S_FMEM) || (st == S_OMEM);
  assign mem_we    = (st == S_OMEM) && (ir_op == OP_STORE);
  assign mem_addr  = mar;
  assign mem_wdata = ac;
  assign halted    = (st == S_HALT);
  assign acc       = ac;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_FADR;
      pc <= '0;
      mar <= '0;
      mbr <= '0;
      ir <= '0;
      ibr <= '0;
      ibr_full <= 1'b0;
      ac <= '0;
    end else begin
      case (st)
        S_FADR: begin
          mar <= pc;
          st <= S_FMEM;
        end
        S_FMEM: if (mem_ready) begin
          mbr <= mem_rdata;
          st <= S_SPLIT;
        end
        S_SPLIT: begin
          ir <= mbr[HALF_W-1:0];
          ibr <= mbr[WORD_W-1:HALF_W];
          ibr_full <= 1'b1;
          st <= S_DEC;
        end
        S_DEC: begin
          if (ir_op == OP_HALT) st <= S_HALT;
          else if (ir_op == OP_JUMP) begin
            pc <= ir_adr;
            ibr_full <= 1'b0;
            st <= S_FADR;
          end else if (is_mem_op) begin
            mar <= ir_adr;
            st <= S_OMEM;
          end else st <= S_NEXT;
        end
        S_OMEM: if (mem_ready) begin
          if (ir_op == OP_STORE) st <= S_NEXT;
          else begin
            mbr <= mem_rdata;
            st <= S_EXEC;
          end
        end
        S_EXEC: begin
          case (ir_op)
            OP_LOAD: ac <= mbr;
            OP_ADD:  ac <= ac + mbr;
            OP_SUB:  ac <= ac - mbr;
            default: ac <= ac;
          endcase
          st <= S_NEXT;
        end
        S_NEXT: begin
          if (ibr_full) begin
            ir <= ibr;
            ibr_full <= 1'b0;
            st <= S_DEC;
          end else begin
            pc <= pc + 1'b1;
            st <= S_FADR;
          end
        end
        default: st <= S_HALT;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
  AST_WE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req); // R6
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(ac)); // R8
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req); // R8
  AST_AC_ONLY_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    st != S_EXEC |=> $stable(ac)); // R9
  AST_PC_HOLD_MID: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_NEXT && ibr_full |=> $stable(pc)); // R11
  AST_JUMP_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_DEC && ir_op == OP_JUMP && ir_op != OP_HALT |=>
      st == S_FADR && !ibr_full && pc == $past(ir_adr)); // R7

endmodule

// File: tb/dual_slot_acc_seq_bench.sv
`timescale 1ns/1ps
module dual_slot_acc_seq_bench;
  localparam logic [7:0] LD = 8'h01, ST = 8'h02, AD = 8'h03, SB = 8'h04,
                         JP = 8'h05, HL = 8'hFF;

  logic clk = 0, rst_n = 0;
  logic mem_req, mem_we, mem_ready = 0, halted;
  logic [11:0] mem_addr;
  logic [39:0] mem_wdata, mem_rdata = '0, acc;

  always #5 clk = ~clk;

  dual_slot_acc_seq #(.OP_LOAD(LD), .OP_STORE(ST), .OP_ADD(AD), .OP_SUB(SB),
    .OP_JUMP(JP), .OP_HALT(HL)) u_dual_slot_acc_seq (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .halted(halted), .acc(acc));

  logic [39:0] mem [0:255];
  int lat = 0, cnt = 0, hold_err = 0, log_n = 0;
  int log_addr [0:63];
  logic log_we [0:63];
  logic [11:0] held_addr;
  logic held_we;
  int checks = 0, failures = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 0;
      cnt = 0;
    end else if (mem_req && !mem_ready) begin
      if (cnt == 0) begin
        held_addr = mem_addr;
        held_we = mem_we;
      end else if (mem_addr != held_addr || mem_we != held_we) hold_err++;
      if (cnt >= lat) begin
        mem_ready = 1;
        cnt = 0;
        if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
        else mem_rdata = mem[mem_addr[7:0]];
        if (log_n < 64) begin
          log_addr[log_n] = int'(mem_addr);
          log_we[log_n] = mem_we;
        end
        log_n++;
      end else cnt++;
    end else mem_ready = 0;
  end

  function automatic logic [19:0] ins(input logic [7:0] op, input logic [11:0] a);
    return {a, op};
  endfunction

  function automatic logic [39:0] wrd(input logic [19:0] l, input logic [19:0] r);
    return {r, l};
  endfunction

  function automatic int reads_of(input int a);
    int n = 0;
    for (int i = 0; i < log_n && i < 64; i++) if (log_addr[i] == a && !log_we[i]) n++;
    return n;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic start(input int l);
    rst_n = 0;
    lat = l;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (2) @(negedge clk);
    log_n = 0;
    hold_err = 0;
  endtask

  task automatic go();
    rst_n = 1;
  endtask

  task automatic run_to_halt();
    int n = 0;
    while (!halted && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk("R8", "halted", 64'(halted), 64'd1);
  endtask

  task automatic t_reset();
    start(0);
    chk("R1", "halted in reset", 64'(halted), 64'd0);
    chk("R1", "acc in reset", 64'(acc), 64'd0);
    mem[0] = wrd(ins(HL, 0), ins(HL, 0));
    go();
    @(negedge clk);
    chk("R1", "acc after release", 64'(acc), 64'd0);
    run_to_halt();
    chk("R1", "first access addr", 64'(log_addr[0]), 64'd0);
    chk("R1", "first access is read", 64'(log_we[0]), 64'd0);
  endtask

  task automatic t_arith(input int l);
    start(l);
    mem[0] = wrd(ins(LD, 100), ins(AD, 101));
    mem[1] = wrd(ins(SB, 102), ins(ST, 103));
    mem[2] = wrd(ins(HL, 0), ins(LD, 100));
    mem[100] = 40'd5;
    mem[101] = 40'hFF_FFFF_FFFF;
    mem[102] = 40'd10;
    go();
    run_to_halt();
    chk("R5", "acc after load/add/sub", 64'(acc), 64'hFF_FFFF_FFFA);
    chk("R6", "stored word", 64'(mem[103]), 64'hFF_FFFF_FFFA);
    chk("R2", "word 0 read once", 64'(reads_of(0)), 64'd1);
    chk("R2", "word 1 read once", 64'(reads_of(1)), 64'd1);
    chk("R4", "add operand order", 64'(log_addr[2]), 64'd101);
    chk("R11", "access count", 64'(log_n), 64'd7);
    chk("R11", "second fetch is word 1", 64'(log_addr[3]), 64'd1);
    chk("R11", "third fetch is word 2", 64'(log_addr[6]), 64'd2);
    chk("R6", "store is a write", 64'(log_we[5]), 64'd1);
    chk("R10", "request stable while waiting", 64'(hold_err), 64'd0);
  endtask

  task automatic t_load_add(input int l);
    start(l);
    mem[0] = wrd(ins(LD, 110), ins(AD, 111));
    mem[1] = wrd(ins(HL, 0), ins(HL, 0));
    mem[110] = 40'h12_3456_789A;
    mem[111] = 40'h01_0000_0001;
    go();
    run_to_halt();
    chk("R3", "loaded value reached acc", 64'(acc), 64'h13_3456_789B);
    chk("R4", "add without wrap", 64'(reads_of(111)), 64'd1);
  endtask

  task automatic t_jump_left();
    start(0);
    mem[0] = wrd(ins(JP, 5), ins(LD, 100));
    mem[5] = wrd(ins(LD, 101), ins(HL, 0));
    mem[100] = 40'd77;
    mem[101] = 40'd33;
    go();
    run_to_halt();
    chk("R7", "acc after left jump", 64'(acc), 64'd33);
    chk("R7", "discarded right half not run", 64'(reads_of(100)), 64'd0);
    chk("R7", "next access is target", 64'(log_addr[1]), 64'd5);
  endtask

  task automatic t_jump_right(input int l);
    start(l);
    mem[0] = wrd(ins(LD, 100), ins(JP, 7));
    mem[1] = wrd(ins(LD, 102), ins(HL, 0));
    mem[7] = wrd(ins(AD, 101), ins(HL, 0));
    mem[100] = 40'd1000;
    mem[101] = 40'd24;
    mem[102] = 40'd9;
    go();
    run_to_halt();
    chk("R7", "acc after right jump", 64'(acc), 64'd1024);
    chk("R7", "word 1 skipped", 64'(reads_of(1)), 64'd0);
    chk("R7", "target fetched after jump", 64'(log_addr[2]), 64'd7);
  endtask

  task automatic t_halt_freeze();
    int n0;
    logic [39:0] a0;
    start(0);
    mem[0] = wrd(ins(LD, 100), ins(HL, 0));
    mem[1] = wrd(ins(ST, 104), ins(ST, 104));
    mem[100] = 40'hAB;
    go();
    run_to_halt();
    n0 = log_n;
    a0 = acc;
    repeat (20) @(negedge clk);
    chk("R8", "no access after halt", 64'(log_n), 64'(n0));
    chk("R8", "acc frozen", 64'(acc), 64'(a0));
    chk("R8", "still halted", 64'(halted), 64'd1);
    chk("R8", "later word untouched", 64'(mem[104]), 64'd0);
    start(0);
    mem[0] = wrd(ins(HL, 0), ins(LD, 100));
    mem[100] = 40'h55;
    go();
    run_to_halt();
    repeat (5) @(negedge clk);
    chk("R8", "left halt stops right half", 64'(acc), 64'd0);
    chk("R8", "left halt accesses", 64'(log_n), 64'd1);
  endtask

  task automatic t_nop();
    start(0);
    mem[0] = wrd(ins(8'h00, 100), ins(8'h7E, 101));
    mem[1] = wrd(ins(LD, 102), ins(HL, 0));
    mem[100] = 40'd1;
    mem[101] = 40'd2;
    mem[102] = 40'd3;
    go();
    run_to_halt();
    chk("R9", "acc after no-ops", 64'(acc), 64'd3);
    chk("R9", "no-op made no access", 64'(reads_of(100) + reads_of(101)), 64'd0);
    chk("R9", "advanced to word 1", 64'(log_addr[1]), 64'd1);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_arith(0);
    t_arith(3);
    t_load_add(0);
    t_load_add(2);
    t_jump_left();
    t_jump_right(0);
    t_jump_right(3);
    t_halt_freeze();
    t_nop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule